// File: doc/BRIEF.md
# SPI Master with DMA Word FIFO

This block is an SPI master that moves words between a memory-side DMA request/grant handshake and a three-wire serial link (SCK, MOSI, MISO). A four-entry word FIFO decouples the DMA side from the shifter. The direction is chosen by a mode input.

In transmit mode the block asks for memory reads while the FIFO has room. It moves words through a transmit buffer into the shift register and sends them. In receive mode it runs the link continuously, captures each word in a receive buffer, passes it into the FIFO, and asks for memory writes while the FIFO holds data. A word-count register limits how many DMA transfers are requested. The two directions stop in different ways: transmit stops when its stored data runs out, receive stops when it is disabled. When the receive path backs up, a policy input decides whether the newest word replaces the one held in the receive buffer or is thrown away.

Top module: `spi_dma_master`

## Requirements
- R1: In transmit mode (`tx_mode`=1), `dma_req` is high whenever `enable` is high, `count_left` is nonzero and the 4-word FIFO is not full. Each grant (`dma_req` and `dma_gnt` both high at a rising clock edge) pushes `dma_wdata` into the FIFO.
- R2: In receive mode (`tx_mode`=0), `dma_req` is high whenever `count_left` is nonzero and the FIFO is not empty. `dma_rdata` shows the oldest FIFO word while `dma_req` is high, and each grant removes that word.
- R3: A `count_load` pulse loads `count_value` into `count_left` and clears `ovf_flag`. Each grant decrements `count_left`. `dma_req` is never high while `count_left` is zero.
- R4: In transmit mode, once the count reaches zero the block keeps shifting until every stored word has been sent. It then drops `busy` and sends nothing more.
- R5: In receive mode the block keeps starting new words while `enable` is high, whatever the count. After `enable` falls, the word in progress completes and no new word starts.
- R6: Words leave on the link in grant order, with each word moved from the transmit buffer into the shift register when it starts. Received words reach memory in arrival order, with each word moved from the shift register into the receive buffer when it ends.
- R7: The link uses SPI mode 0. SCK idles low, MOSI sends MSB first, and MISO is sampled on the SCK rising edge. Each SCK half period lasts `sck_div`+1 clocks. With `wide`=1 a word is 16 bits. With `wide`=0 a word is 8 bits, taken from the low byte when sent and zero-extended when received.
- R8: The receive buffer is a one-word stage ahead of the FIFO. If a word completes while that buffer still holds a word that cannot move into the full FIFO, and `overwrite`=1, the new word replaces the held word.
- R9: In the same situation with `overwrite`=0, the new word is discarded and the held word is kept.
- R10: `ovf_flag` goes high when a word is replaced or discarded, and stays high until the next `count_load`.
- R11: In receive mode the transmit buffer counts as empty, and every word sent on MOSI is all ones.
- R12: After reset, `dma_req`, `sck`, `busy`, `ovf_flag` and `count_left` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run enable for the link and transmit DMA |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| wide | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| overwrite | input | 1 | Overflow policy: 1 = replace held word, 0 = drop new word |
| sck_div | input | DIV_W | SCK half period minus one, in clocks |
| count_load | input | 1 | Load pulse for the word count |
| count_value | input | CNT_W | Word count to load |
| count_left | output | CNT_W | DMA transfers remaining |
| dma_req | output | 1 | DMA request |
| dma_gnt | input | 1 | DMA grant |
| dma_wdata | input | DATA_W | Word read from memory (transmit) |
| dma_rdata | output | DATA_W | Word to write to memory (receive) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Words held or a transfer in progress |
| ovf_flag | output | 1 | Sticky receive overflow flag |

## Verification
On the receive side, a finished word moving from the receive buffer into the FIFO can fall in the same cycle as a DMA grant that removes the oldest FIFO word. The same applies to a word completing just as the receive buffer drains. The bench provokes this overlap by holding the grant high for a whole receive run, and by filling the FIFO with the grant low before releasing it. It judges the result by comparing every word written to memory, in order, against the sequence it drove on MISO, after the overflow policy has been applied. Every clock it also checks the count and the request against its own count model.

// File: rtl/spi_dma_pkg.sv
// Package: types shared by the SPI DMA master blocks.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package spi_dma_pkg;

    // Transfer direction as decoded from the mode input.
    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } spi_dir_e;

endpackage

// File: rtl/spi_dma_fifo.sv
// Module: spi_dma_fifo
// Synchronous word FIFO. A push when full and a pop when empty are ignored.
// Push and pop may happen in the same cycle. The head word is shown combinationally.
// Assumes a single clock domain and DEPTH >= 2.
module spi_dma_fifo #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     level
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned LW = AW + 1;

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [LW-1:0] cnt;
    logic          do_push;
    logic          do_pop;

    assign full    = (cnt == LW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = store[rd_ptr];
    assign level   = cnt;

    // Write the pushed word into its slot.
    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= push_data;
        end
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/spi_dma_shifter.sv
// Module: spi_dma_shifter
// SPI mode 0 word engine. It makes SCK from a half-period divider, sends MSB first
// and samples MISO on the SCK rising edge. A start pulse while idle loads the word.
// The received word and a one-cycle done pulse appear after the last falling edge.
// Assumes W is even. An 8-bit word uses the low half of the register.
module spi_dma_shifter #(
    parameter int unsigned W     = 16,
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [W-1:0]     load,
    input  logic             wide,
    input  logic [DIV_W-1:0] div,
    input  logic             miso,
    output logic             active,
    output logic             sck,
    output logic             mosi,
    output logic             done,
    output logic [W-1:0]     rx_word
);
    localparam int unsigned BW       = $clog2(W);
    localparam logic [W-1:0] LOW_MASK = {{(W - W/2){1'b0}}, {(W/2){1'b1}}};

    logic [W-1:0]     sh;
    logic [DIV_W-1:0] div_cnt;
    logic [BW-1:0]    bit_cnt;
    logic             smp;
    logic [BW-1:0]    last_bit;
    logic [W-1:0]     merged;
    logic [W-1:0]     keep;

    assign last_bit = wide ? BW'(W - 1) : BW'(W/2 - 1);
    assign merged   = {sh[W-2:0], smp};
    assign keep     = wide ? '1 : LOW_MASK;
    assign mosi     = wide ? sh[W-1] : sh[W/2-1];

    // Step the divider, SCK phase, bit counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            sck     <= 1'b0;
            sh      <= '1;
            div_cnt <= '0;
            bit_cnt <= '0;
            smp     <= 1'b0;
            done    <= 1'b0;
            rx_word <= '0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active  <= 1'b1;
                    sh      <= load;
                    div_cnt <= '0;
                    bit_cnt <= '0;
                    sck     <= 1'b0;
                end
            end else if (div_cnt == div) begin
                div_cnt <= '0;
                if (!sck) begin
                    sck <= 1'b1;
                    smp <= miso;
                end else begin
                    sck <= 1'b0;
                    sh  <= merged;
                    if (bit_cnt == last_bit) begin
                        active  <= 1'b0;
                        done    <= 1'b1;
                        rx_word <= merged & keep;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_dma_master.sv
// Module: spi_dma_master
// SPI master that moves words between a DMA request/grant handshake and the link
// through one shared word FIFO. In transmit mode the FIFO feeds a transmit buffer,
// which feeds the shifter. In receive mode the shifter feeds a receive buffer,
// which feeds the FIFO. The receive buffer applies the overflow policy.
// Assumes the mode, size and policy inputs stay stable while words are in flight.
module spi_dma_master
    import spi_dma_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned FIFO_DEPTH = 4,
    parameter int unsigned DIV_W      = 8,
    parameter int unsigned CNT_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tx_mode,
    input  logic              wide,
    input  logic              overwrite,
    input  logic [DIV_W-1:0]  sck_div,
    input  logic              count_load,
    input  logic [CNT_W-1:0]  count_value,
    output logic [CNT_W-1:0]  count_left,
    output logic              dma_req,
    input  logic              dma_gnt,
    input  logic [DATA_W-1:0] dma_wdata,
    output logic [DATA_W-1:0] dma_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              busy,
    output logic              ovf_flag
);
    localparam int unsigned LVL_W = $clog2(FIFO_DEPTH) + 1;

    spi_dir_e          dir;
    logic              grant;
    logic [CNT_W-1:0]  cnt_r;

    logic              fifo_push;
    logic              fifo_pop;
    logic [DATA_W-1:0] fifo_din;
    logic [DATA_W-1:0] fifo_head;
    logic              fifo_full;
    logic              fifo_empty;
    logic [LVL_W-1:0]  fifo_level;

    logic [DATA_W-1:0] tdbr;
    logic              tdbr_v;
    logic              tdbr_fill;
    logic [DATA_W-1:0] rdbr;
    logic              rdbr_v;
    logic              rdbr_drain;
    logic              word_in;
    logic              ovf_r;

    logic              sh_start;
    logic [DATA_W-1:0] sh_load;
    logic              sh_active;
    logic              sh_done;
    logic [DATA_W-1:0] sh_rx;

    assign dir = spi_dir_e'(tx_mode);

    // DMA request: fill in transmit mode, drain in receive mode, both gated by the count.
    always_comb begin
        if (cnt_r == '0) begin
            dma_req = 1'b0;
        end else if (dir == DIR_TX) begin
            dma_req = enable && !fifo_full;
        end else begin
            dma_req = !fifo_empty;
        end
    end

    assign grant      = dma_req && dma_gnt;
    assign dma_rdata  = fifo_head;
    assign count_left = cnt_r;

    // Word count register: load on request, count down on each grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_r <= '0;
        end else if (count_load) begin
            cnt_r <= count_value;
        end else if (grant) begin
            cnt_r <= cnt_r - 1'b1;
        end
    end

    // Shifter start: a buffered word in transmit mode, free-running in receive mode.
    assign sh_start  = enable && !sh_active && ((dir == DIR_TX) ? tdbr_v : 1'b1);
    assign sh_load   = (dir == DIR_TX) ? tdbr : '1;
    assign tdbr_fill = (dir == DIR_TX) && !fifo_empty && (!tdbr_v || sh_start);

    // Transmit buffer: refill from the FIFO, empty into the shifter at word start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tdbr   <= '0;
            tdbr_v <= 1'b0;
        end else if (tdbr_fill) begin
            tdbr   <= fifo_head;
            tdbr_v <= 1'b1;
        end else if (sh_start && (dir == DIR_TX)) begin
            tdbr_v <= 1'b0;
        end
    end

    assign word_in    = (dir == DIR_RX) && sh_done;
    assign rdbr_drain = (dir == DIR_RX) && rdbr_v && !fifo_full;

    // Receive buffer: capture each finished word and apply the overflow policy when blocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdbr   <= '0;
            rdbr_v <= 1'b0;
        end else if (word_in) begin
            if (rdbr_v && !rdbr_drain) begin
                if (overwrite) begin
                    rdbr <= sh_rx;
                end
            end else begin
                rdbr   <= sh_rx;
                rdbr_v <= 1'b1;
            end
        end else if (rdbr_drain) begin
            rdbr_v <= 1'b0;
        end
    end

    // Sticky overflow flag, cleared by a count load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_r <= 1'b0;
        end else if (count_load) begin
            ovf_r <= 1'b0;
        end else if (word_in && rdbr_v && !rdbr_drain) begin
            ovf_r <= 1'b1;
        end
    end

    assign ovf_flag = ovf_r;

    // FIFO port steering by direction.
    assign fifo_push = (dir == DIR_TX) ? grant : rdbr_drain;
    assign fifo_din  = (dir == DIR_TX) ? dma_wdata : rdbr;
    assign fifo_pop  = (dir == DIR_TX) ? tdbr_fill : grant;

    assign busy = sh_active || tdbr_v || rdbr_v || (fifo_level != '0);

    spi_dma_fifo #(
        .W     (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (fifo_din),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .full      (fifo_full),
        .empty     (fifo_empty),
        .level     (fifo_level)
    );

    spi_dma_shifter #(
        .W     (DATA_W),
        .DIV_W (DIV_W)
    ) shifter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .load    (sh_load),
        .wide    (wide),
        .div     (sck_div),
        .miso    (miso),
        .active  (sh_active),
        .sck     (sck),
        .mosi    (mosi),
        .done    (sh_done),
        .rx_word (sh_rx)
    );

endmodule

// File: rtl/spi_dma_master_sva.sv
// Module: spi_dma_master_sva
// Checker bound to spi_dma_master. It watches the count, the request, SCK and the flag.
// Assumes a synchronous active-low reset.
module spi_dma_master_sva #(
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned LVL_W      = 3,
    parameter int unsigned FIFO_DEPTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             count_load,
    input logic [CNT_W-1:0] count_left,
    input logic             dma_req,
    input logic             dma_gnt,
    input logic             sck,
    input logic             busy,
    input logic             ovf_flag,
    input logic [LVL_W-1:0] fifo_level
);
    assert_no_req_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (count_left == '0) |-> !dma_req);

    assert_count_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_gnt && !count_load) |=> (count_left == $past(count_left) - 1'b1));

    assert_sck_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !count_load) |=> ovf_flag);

    assert_fifo_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(FIFO_DEPTH));

endmodule

bind spi_dma_master spi_dma_master_sva #(
    .CNT_W      (CNT_W),
    .LVL_W      (LVL_W),
    .FIFO_DEPTH (FIFO_DEPTH)
) sva_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_load (count_load),
    .count_left (count_left),
    .dma_req    (dma_req),
    .dma_gnt    (dma_gnt),
    .sck        (sck),
    .busy       (busy),
    .ovf_flag   (ovf_flag),
    .fifo_level (fifo_level)
);

// File: tb/spi_dma_master_tb.sv
// Bench for spi_dma_master: a behavioural count model checked every clock,
// a serial monitor on MOSI, a MISO word source and a DMA memory model.
module spi_dma_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int CNT_W      = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        tx_mode = 1'b0;
    logic        wide = 1'b1;
    logic        overwrite = 1'b0;
    logic [7:0]  sck_div = 8'd1;
    logic        count_load = 1'b0;
    logic [15:0] count_value = '0;
    logic [15:0] count_left;
    logic        dma_req;
    logic        dma_gnt = 1'b0;
    logic [15:0] dma_wdata = '0;
    logic [15:0] dma_rdata;
    logic        sck;
    logic        mosi;
    logic        miso = 1'b0;
    logic        busy;
    logic        ovf_flag;

    int          chk_cnt = 0;
    int          fail_cnt = 0;
    int          cyc = 0;
    int          nb = 16;
    int          divv = 1;
    bit          tx_run = 0;
    int          mcount = 0;
    int          gnt_mode = 0;
    bit          load_pend = 0;
    int          load_val = 0;
    bit          saw_bp = 0;
    int          tx_idx = 0;
    int          link_words = 0;
    int          bits_seen = 0;
    int          last_rise = 0;
    int          mbit = 0;
    logic [15:0] cur_word = '0;
    logic [15:0] mem_q[$];
    logic [15:0] tx_list [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_dma_master dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tx_mode(tx_mode), .wide(wide),
        .overwrite(overwrite), .sck_div(sck_div), .count_load(count_load),
        .count_value(count_value), .count_left(count_left), .dma_req(dma_req),
        .dma_gnt(dma_gnt), .dma_wdata(dma_wdata), .dma_rdata(dma_rdata), .sck(sck),
        .mosi(mosi), .miso(miso), .busy(busy), .ovf_flag(ovf_flag)
    );

    function automatic logic [15:0] wmask();
        return (nb == 16) ? 16'hFFFF : 16'h00FF;
    endfunction

    function automatic logic [15:0] fword(int j);
        return 16'(j * 4951 + 42) & wmask();
    endfunction

    function automatic logic sbit(int k);
        logic [15:0] w;
        w = fword(k / nb);
        return w[nb - 1 - (k % nb)];
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        chk_cnt++;
        if (!ok) begin
            fail_cnt++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Count model, per-clock checks and DMA memory model.
    always @(negedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            chk_cnt++;
            fail_cnt++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
            $display("%0d/%0d checks passed", chk_cnt - fail_cnt, chk_cnt);
            $finish;
        end
        if (rst_n) begin
            check(count_left == mcount[CNT_W-1:0], "R3 count", count_left, mcount);
            check(!(dma_req && mcount == 0), "R3 req at zero", dma_req, 0);
            check(!(sck && !busy), "R7 sck idle", sck, 0);
            if (tx_run && enable && mcount != 0 && !dma_req) saw_bp = 1;
        end
        count_load = 1'b0;
        dma_gnt    = 1'b0;
        if (load_pend) begin
            count_load  = 1'b1;
            count_value = 16'(load_val);
            mcount      = load_val;
            load_pend   = 0;
        end else begin
            if (gnt_mode == 1) dma_gnt = 1'b1;
            else if (gnt_mode == 2) dma_gnt = (cyc % 3 != 0);
            if (dma_gnt && dma_req && rst_n) begin
                mcount--;
                if (tx_mode) begin
                    dma_wdata = tx_list[tx_idx % 16];
                    tx_idx++;
                end else begin
                    mem_q.push_back(dma_rdata);
                end
            end
        end
    end

    // Serial monitor: SCK period and MOSI words.
    always @(posedge sck) begin : mon
        logic [15:0] e;
        if (bits_seen % nb != 0)
            check(cyc - last_rise == 2 * (divv + 1), "R7 half period", cyc - last_rise, 2 * (divv + 1));
        last_rise = cyc;
        cur_word  = {cur_word[14:0], mosi};
        bits_seen++;
        if (bits_seen % nb == 0) begin
            e = tx_run ? (tx_list[link_words % 16] & wmask()) : wmask();
            check((cur_word & wmask()) == e, tx_run ? "R6 tx word" : "R11 rx mosi ones",
                  cur_word & wmask(), e);
            link_words++;
        end
    end

    // MISO source: next bit after each falling SCK edge.
    always @(negedge sck) begin
        mbit++;
        miso = sbit(mbit);
    end

    task automatic clear_bench();
        link_words = 0;
        bits_seen  = 0;
        mem_q.delete();
        tx_idx = 0;
        mbit   = 0;
        miso   = sbit(0);
        saw_bp = 0;
    endtask

    task automatic do_load(input int v);
        load_val  = v;
        load_pend = 1;
        while (load_pend) @(posedge clk);
    endtask

    task automatic setup(input bit tx, input bit w, input int d, input bit ovw);
        @(negedge clk);
        tx_mode   = tx;
        wide      = w;
        nb        = w ? 16 : 8;
        divv      = d;
        sck_div   = 8'(d);
        overwrite = ovw;
        tx_run    = tx;
        clear_bench();
    endtask

    task automatic run_tx(input int n, input bit w, input int d, input int g);
        setup(1'b1, w, d, 1'b0);
        gnt_mode = g;
        do_load(n);
        @(negedge clk);
        enable = 1'b1;
        while (!(link_words == n && !busy)) @(negedge clk);
        repeat (100) @(negedge clk);
        check(link_words == n, "R4 tx word total", link_words, n);
        check(busy == 1'b0, "R4 tx busy low", busy, 0);
        check(count_left == 0, "R3 tx count expired", count_left, 0);
        enable   = 1'b0;
        gnt_mode = 0;
        tx_run   = 0;
    endtask

    task automatic run_rx(input int n, input bit w, input int d, input bit ovw, input int cnt, input int g);
        setup(1'b0, w, d, ovw);
        gnt_mode = g;
        do_load(cnt);
        @(negedge clk);
        enable = 1'b1;
        while (bits_seen < (n - 1) * nb + 1) @(negedge clk);
        enable = 1'b0;
        while (link_words < n) @(negedge clk);
        repeat (20) @(negedge clk);
        check(link_words == n, "R5 rx stops after enable low", link_words, n);
    endtask

    task automatic check_mem(input int idx, input int j, input string tag);
        if (mem_q.size() > idx) check(mem_q[idx] == fword(j), tag, mem_q[idx], fword(j));
        else check(1'b0, tag, mem_q.size(), idx + 1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) tx_list[i] = 16'(16'hC35A ^ (i * 16'h0F1D));
        repeat (5) @(negedge clk);
        check(dma_req == 1'b0, "R12 reset req", dma_req, 0);
        check(sck == 1'b0, "R12 reset sck", sck, 0);
        check(busy == 1'b0, "R12 reset busy", busy, 0);
        check(ovf_flag == 1'b0, "R12 reset ovf", ovf_flag, 0);
        check(count_left == 0, "R12 reset count", count_left, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 R4 R6: 16-bit transmit with a gapped grant pattern.
        run_tx(6, 1'b1, 1, 2);
        // R1 R7: 8-bit transmit, grant always high, FIFO back-pressure.
        run_tx(8, 1'b0, 2, 1);
        check(saw_bp == 1'b1, "R1 request drops when FIFO full", saw_bp, 1);

        // R2 R5 R11: receive with grant high, count expires before the link stops.
        run_rx(6, 1'b1, 1, 1'b0, 3, 1);
        check(mem_q.size() == 3, "R3 rx writes stop at count zero", mem_q.size(), 3);
        for (int i = 0; i < 3; i++) check_mem(i, i, "R2 rx word order");
        check(ovf_flag == 1'b0, "R10 no overflow", ovf_flag, 0);
        do_load(3);
        repeat (20) @(negedge clk);
        for (int i = 3; i < 6; i++) check_mem(i, i, "R6 rx words kept after count expiry");
        check(busy == 1'b0, "R2 rx drained", busy, 0);

        // R8: overflow with replace policy, 8-bit words.
        run_rx(7, 1'b0, 0, 1'b1, 5, 0);
        check(ovf_flag == 1'b1, "R10 ovf set on replace", ovf_flag, 1);
        gnt_mode = 1;
        repeat (30) @(negedge clk);
        for (int i = 0; i < 4; i++) check_mem(i, i, "R8 fifo words");
        check_mem(4, 6, "R8 newest word replaced held word");
        check(mem_q.size() == 5, "R8 word total", mem_q.size(), 5);
        gnt_mode = 0;

        // R9: overflow with drop policy, 16-bit words.
        run_rx(7, 1'b1, 1, 1'b0, 5, 0);
        check(ovf_flag == 1'b1, "R10 ovf set on drop", ovf_flag, 1);
        gnt_mode = 1;
        repeat (30) @(negedge clk);
        for (int i = 0; i < 5; i++) check_mem(i, i, "R9 held word kept, new dropped");
        check(mem_q.size() == 5, "R9 word total", mem_q.size(), 5);
        gnt_mode = 0;
        do_load(0);
        @(negedge clk);
        check(ovf_flag == 1'b0, "R10 ovf cleared by load", ovf_flag, 0);

        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", chk_cnt - fail_cnt, chk_cnt);
        $finish;
    end

endmodule